// File: doc/BRIEF.md
# Control-Transfer Decision Unit

This unit decides where a stack processor fetches from next. On each executed instruction it receives the kind of transfer (plain, branch, call, exit or repeat), a 3-bit condition selector, the two top data-stack words, the sign, overflow and carry status flags, and the word on top of the return stack. In the same cycle it reports how many data-stack words to pop and whether to push to or pop from the return stack. It also holds the program counter and returns the new value after the clock edge.

One condition code set applies to branches, calls and exits. The zero and non-zero tests examine a flag taken from the data stack. The other tests examine the status flags. Offsets are signed, come from the top of stack, and are added to the address of the following instruction. The sum wraps within the address space.

A repeat instruction loads a count from the top of stack and makes the next instruction run that count plus one times. The PC holds on that instruction until the last pass. When the step strobe is low, nothing moves. This lets an interrupt controller take the slot between passes, and execution resumes with the count that was left.

Top module: `cfu_flow_unit`

## Requirements
- R1: After reset the PC equals the parameter RESET_PC (default 0x0100), the repeat indication is low and the remaining count is zero.
- R2: Condition encodings: 0 always, 1 never, 2 zero, 3 non-zero, 4 sign set, 5 sign clear, 6 overflow clear, 7 carry clear. A taken branch sets PC to PC+1 plus the top-of-stack offset.
- R3: A branch pops its offset whether or not it is taken. With condition zero or non-zero it also pops the flag, which is the second stack word, so ds_pop is 2; otherwise ds_pop is 1.
- R4: A taken call writes PC+1 to the return stack (rs_push with rs_wdata) and jumps as a branch would. A call that is not taken pushes nothing. Its data-stack pops match those of a branch.
- R5: An exit with condition zero or non-zero pops one flag from the top of stack and tests it. A taken exit pops the return stack and loads the PC from rs_top.
- R6: Sign, sign-clear, overflow-clear and carry-clear tests use the status flag inputs. An exit with one of these conditions pops no data.
- R7: Condition never: a call acts as a single drop (ds_pop 1, no return-stack traffic), and an exit is a no-op that only advances the PC.
- R8: A plain instruction (kind 0) advances the PC by one and makes no stack request. Kind codes: 0 plain, 1 branch, 2 call, 3 exit, 4 repeat.
- R9: A repeat (kind 4) pops n-1 from the top of stack and advances the PC. The following instruction then executes n times: the PC holds for n-1 executions while rep_left counts down, and the last execution advances the PC and clears rep_active.
- R10: While step is low, the PC and the repeat state stay unchanged and every stack request is low. A repeat can therefore pause between passes and resume with its remaining count.
- R11: Target addresses wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | The instruction at pc executes this cycle |
| kind | input | 3 | Transfer kind: 0 plain, 1 branch, 2 call, 3 exit, 4 repeat |
| cond | input | 3 | Condition selector (encoding in R2) |
| tos | input | DW | Top data-stack word: offset, exit flag or repeat count |
| nos | input | DW | Second data-stack word: flag of a conditional branch or call |
| flag_sign | input | 1 | Status sign flag |
| flag_ovl | input | 1 | Status overflow flag |
| flag_carry | input | 1 | Status carry flag |
| rs_top | input | AW | Return-stack top, the exit target |
| pc | output | AW | Address of the current instruction |
| rs_push | output | 1 | Push rs_wdata onto the return stack |
| rs_wdata | output | AW | Return address (pc+1) |
| rs_pop | output | 1 | Pop the return stack |
| ds_pop | output | 2 | Number of data-stack words to pop |
| rep_active | output | 1 | A repeat is in progress |
| rep_left | output | DW | Repetitions still to come after the current pass |

## Verification
The stack requests (ds_pop, rs_push, rs_wdata, rs_pop) are combinational in the executing cycle. The bench therefore drives each instruction just after a falling edge and reads these requests one time unit later, before the rising edge. The PC, rep_active and rep_left are registered and change at the rising edge that closes the step. The bench reads them after the following falling edge. Stall windows are checked the same way on every idle cycle, so a count that changes or a PC that drifts during a pause shows up on the first affected cycle.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    typedef enum logic [2:0] {
        K_SEQ    = 3'd0,
        K_BRANCH = 3'd1,
        K_CALL   = 3'd2,
        K_EXIT   = 3'd3,
        K_REPEAT = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        C_ALWAYS = 3'd0,
        C_NEVER  = 3'd1,
        C_ZERO   = 3'd2,
        C_NZERO  = 3'd3,
        C_SIGN   = 3'd4,
        C_NSIGN  = 3'd5,
        C_NOVL   = 3'd6,
        C_NCARRY = 3'd7
    } cond_e;

    typedef struct packed {
        logic sign;
        logic ovl;
        logic carry;
    } flags_t;

endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
    import cfu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    cond,
    input  logic [DW-1:0] flag_word,
    input  flags_t        flags,
    output logic          taken,
    output logic          uses_flag
);

    logic word_is_zero;

    assign word_is_zero = (flag_word == '0);

    always_comb begin
        uses_flag = 1'b0;
        case (cond_e'(cond))
            C_ALWAYS: taken = 1'b1;
            C_NEVER:  taken = 1'b0;
            C_ZERO: begin
                taken     = word_is_zero;
                uses_flag = 1'b1;
            end
            C_NZERO: begin
                taken     = !word_is_zero;
                uses_flag = 1'b1;
            end
            C_SIGN:   taken = flags.sign;
            C_NSIGN:  taken = !flags.sign;
            C_NOVL:   taken = !flags.ovl;
            C_NCARRY: taken = !flags.carry;
            default:  taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfu_target_calc.sv
module cfu_target_calc #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pc_cur,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] pc_seq,
    output logic [AW-1:0] pc_tgt
);

    // Adding the low AW bits gives the same result modulo 2^AW as a
    // sign-extended add, so wrap comes for free.
    assign pc_seq = pc_cur + AW'(1);
    assign pc_tgt = pc_seq + offset;

endmodule

// File: rtl/cfu_repeat_step.sv
module cfu_repeat_step #(
    parameter int DW = 32
) (
    input  logic          step,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          active_q,
    input  logic [DW-1:0] left_q,
    output logic          hold,
    output logic          active_d,
    output logic [DW-1:0] left_d
);

    assign hold = active_q && (left_q != '0);

    always_comb begin
        active_d = active_q;
        left_d   = left_q;
        if (step) begin
            if (hold) begin
                left_d = left_q - DW'(1);
            end else if (load) begin
                active_d = 1'b1;
                left_d   = load_val;
            end else begin
                active_d = 1'b0;
                left_d   = '0;
            end
        end
    end

endmodule

// File: rtl/cfu_flow_unit.sv
module cfu_flow_unit
    import cfu_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 32,
    parameter logic [15:0] RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [2:0]    kind,
    input  logic [2:0]    cond,
    input  logic [DW-1:0] tos,
    input  logic [DW-1:0] nos,
    input  logic          flag_sign,
    input  logic          flag_ovl,
    input  logic          flag_carry,
    input  logic [AW-1:0] rs_top,
    output logic [AW-1:0] pc,
    output logic          rs_push,
    output logic [AW-1:0] rs_wdata,
    output logic          rs_pop,
    output logic [1:0]    ds_pop,
    output logic          rep_active,
    output logic [DW-1:0] rep_left
);

    localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] left;
        logic          active;
    } state_t;

    state_t st_q, st_d;

    kind_e         kind_e_w;
    logic [DW-1:0] flag_word;
    logic          taken;
    logic          uses_flag;
    logic [AW-1:0] pc_seq;
    logic [AW-1:0] pc_tgt;
    logic          hold;
    logic          load_rep;
    logic          rep_active_d;
    logic [DW-1:0] rep_left_d;
    flags_t        flags;

    assign kind_e_w  = kind_e'(kind);
    assign flag_word = (kind_e_w == K_EXIT) ? tos : nos;
    assign flags     = '{sign: flag_sign, ovl: flag_ovl, carry: flag_carry};
    assign load_rep  = (kind_e_w == K_REPEAT);

    cfu_cond_eval #(.DW(DW)) u_cond (
        .cond      (cond),
        .flag_word (flag_word),
        .flags     (flags),
        .taken     (taken),
        .uses_flag (uses_flag)
    );

    cfu_target_calc #(.AW(AW)) u_tgt (
        .pc_cur (st_q.pc),
        .offset (tos[AW-1:0]),
        .pc_seq (pc_seq),
        .pc_tgt (pc_tgt)
    );

    cfu_repeat_step #(.DW(DW)) u_rep (
        .step     (step),
        .load     (load_rep),
        .load_val (tos),
        .active_q (st_q.active),
        .left_q   (st_q.left),
        .hold     (hold),
        .active_d (rep_active_d),
        .left_d   (rep_left_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.active = rep_active_d;
        st_d.left   = rep_left_d;
        rs_push     = 1'b0;
        rs_pop      = 1'b0;
        ds_pop      = 2'd0;
        if (step && !hold) begin
            case (kind_e_w)
                K_SEQ: st_d.pc = pc_seq;
                K_BRANCH: begin
                    ds_pop  = uses_flag ? 2'd2 : 2'd1;
                    st_d.pc = taken ? pc_tgt : pc_seq;
                end
                K_CALL: begin
                    ds_pop  = uses_flag ? 2'd2 : 2'd1;
                    rs_push = taken;
                    st_d.pc = taken ? pc_tgt : pc_seq;
                end
                K_EXIT: begin
                    ds_pop  = uses_flag ? 2'd1 : 2'd0;
                    rs_pop  = taken;
                    st_d.pc = taken ? rs_top : pc_seq;
                end
                K_REPEAT: begin
                    ds_pop  = 2'd1;
                    st_d.pc = pc_seq;
                end
                default: st_d.pc = pc_seq;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc     <= PC_INIT;
            st_q.left   <= '0;
            st_q.active <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc         = st_q.pc;
    assign rs_wdata   = pc_seq;
    assign rep_active = st_q.active;
    assign rep_left   = st_q.left;

endmodule

// File: rtl/cfu_flow_chk.sv
module cfu_flow_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic [2:0]    kind,
    input logic [2:0]    cond,
    input logic [AW-1:0] rs_top,
    input logic [AW-1:0] pc,
    input logic          rs_push,
    input logic [AW-1:0] rs_wdata,
    input logic          rs_pop,
    input logic [1:0]    ds_pop,
    input logic          rep_active,
    input logic [DW-1:0] rep_left
);

    logic iter_hold;
    assign iter_hold = rep_active && (rep_left != '0);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> (!rs_push && !rs_pop && ds_pop == 2'd0));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(pc) && $stable(rep_left) && $stable(rep_active)));

    a_r4_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_push && rs_pop));

    a_r4_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rs_push |-> (rs_wdata == AW'(pc + AW'(1))));

    a_r5_exit_target: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rs_pop) |=> (pc == $past(rs_top)));

    a_r8_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && kind == 3'd0 && !iter_hold) |=> (pc == AW'($past(pc) + AW'(1))));

    a_r9_iter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && iter_hold) |=> (pc == $past(pc) && rep_left == $past(rep_left) - DW'(1)));

    a_r3_branch_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (step && kind == 3'd1 && !iter_hold) |-> (ds_pop != 2'd0));

    a_r7_never_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cond == 3'd1) |-> (!rs_push && !rs_pop));

endmodule

bind cfu_flow_unit cfu_flow_chk #(.AW(AW), .DW(DW)) u_flow_chk (.*);

// File: tb/test_cfu_flow_unit.sv
module test_cfu_flow_unit;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step = 1'b0;
    logic [2:0]    kind = 3'd0;
    logic [2:0]    cond = 3'd0;
    logic [DW-1:0] tos = '0;
    logic [DW-1:0] nos = '0;
    logic          flag_sign = 1'b0;
    logic          flag_ovl = 1'b0;
    logic          flag_carry = 1'b0;
    logic [AW-1:0] rs_top = '0;
    logic [AW-1:0] pc;
    logic          rs_push;
    logic [AW-1:0] rs_wdata;
    logic          rs_pop;
    logic [1:0]    ds_pop;
    logic          rep_active;
    logic [DW-1:0] rep_left;

    int  nvec = 0;
    int  nbad = 0;
    bit  done = 1'b0;
    logic [AW-1:0] epc;

    always #2.5 clk = ~clk;

    cfu_flow_unit #(.AW(AW), .DW(DW), .RESET_PC(16'h0100)) i_cfu_flow_unit (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Executes one instruction; called just after a falling edge.
    task automatic op(input string req, input logic [2:0] k, input logic [2:0] c,
                      input logic [DW-1:0] t, input logic [DW-1:0] n,
                      input logic [2:0] fl, input logic [AW-1:0] rt,
                      input logic [1:0] e_pop, input logic e_push,
                      input logic e_rspop, input logic [AW-1:0] e_pc);
        step = 1'b1; kind = k; cond = c; tos = t; nos = n;
        {flag_sign, flag_ovl, flag_carry} = fl; rs_top = rt;
        #1;
        chk(req, "ds_pop", 32'(ds_pop), 32'(e_pop));
        chk(req, "rs_push", 32'(rs_push), 32'(e_push));
        chk(req, "rs_pop", 32'(rs_pop), 32'(e_rspop));
        if (e_push) chk(req, "rs_wdata", 32'(rs_wdata), 32'(AW'(epc + 1)));
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        #1;
        chk(req, "pc", 32'(pc), 32'(e_pc));
        epc = e_pc;
    endtask

    task automatic idle(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            #1;
            chk(req, "idle requests", 32'({rs_push, rs_pop, ds_pop}), 32'd0);
            @(negedge clk);
            #1;
            chk(req, "idle pc", 32'(pc), 32'(epc));
        end
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "pc", 32'(pc), 32'h0100);
        chk("R1", "rep_active", 32'(rep_active), 32'd0);
        chk("R1", "rep_left", rep_left, 32'd0);
        epc = 16'h0100;
    endtask

    task automatic t_branches();
        op("R8", 3'd0, 3'd0, 32'h0, 32'h0, 3'b000, 16'h0, 2'd0, 0, 0, 16'h0101);
        op("R2", 3'd1, 3'd0, 32'h10, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0112);
        op("R2", 3'd1, 3'd0, 32'hFFFF_FFFD, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0110);
        op("R3", 3'd1, 3'd2, 32'h4, 32'h0, 3'b000, 16'h0, 2'd2, 0, 0, 16'h0115);
        op("R3", 3'd1, 3'd2, 32'h4, 32'h5, 3'b000, 16'h0, 2'd2, 0, 0, 16'h0116);
        op("R3", 3'd1, 3'd3, 32'h8, 32'h7, 3'b000, 16'h0, 2'd2, 0, 0, 16'h011F);
        op("R6", 3'd1, 3'd4, 32'h2, 32'h0, 3'b100, 16'h0, 2'd1, 0, 0, 16'h0122);
        op("R6", 3'd1, 3'd5, 32'h2, 32'h0, 3'b100, 16'h0, 2'd1, 0, 0, 16'h0123);
        op("R6", 3'd1, 3'd6, 32'h1, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0125);
        op("R6", 3'd1, 3'd7, 32'h5, 32'h0, 3'b001, 16'h0, 2'd1, 0, 0, 16'h0126);
        op("R3", 3'd1, 3'd1, 32'h40, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0127);
    endtask

    task automatic t_calls();
        op("R4", 3'd2, 3'd0, 32'h20, 32'h0, 3'b000, 16'h0, 2'd1, 1, 0, 16'h0148);
        op("R7", 3'd2, 3'd1, 32'h20, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0149);
        op("R4", 3'd2, 3'd3, 32'h20, 32'h0, 3'b000, 16'h0, 2'd2, 0, 0, 16'h014A);
    endtask

    task automatic t_exits();
        op("R5", 3'd3, 3'd0, 32'h9, 32'h0, 3'b000, 16'h0128, 2'd0, 0, 1, 16'h0128);
        op("R5", 3'd3, 3'd2, 32'h0, 32'h0, 3'b000, 16'h0300, 2'd1, 0, 1, 16'h0300);
        op("R5", 3'd3, 3'd3, 32'h0, 32'h0, 3'b000, 16'h0700, 2'd1, 0, 0, 16'h0301);
        op("R6", 3'd3, 3'd7, 32'h0, 32'h0, 3'b000, 16'h0400, 2'd0, 0, 1, 16'h0400);
        op("R6", 3'd3, 3'd4, 32'h0, 32'h0, 3'b000, 16'h0500, 2'd0, 0, 0, 16'h0401);
        op("R7", 3'd3, 3'd1, 32'h0, 32'h0, 3'b000, 16'h0600, 2'd0, 0, 0, 16'h0402);
    endtask

    task automatic t_stall();
        idle("R10", 3);
    endtask

    task automatic t_repeat();
        op("R9", 3'd4, 3'd0, 32'd2, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0403);
        chk("R9", "rep_active after load", 32'(rep_active), 32'd1);
        chk("R9", "rep_left after load", rep_left, 32'd2);
        op("R9", 3'd0, 3'd0, 32'h0, 32'h0, 3'b000, 16'h0, 2'd0, 0, 0, 16'h0403);
        chk("R9", "rep_left pass 1", rep_left, 32'd1);
        idle("R10", 2);
        chk("R10", "rep_left kept across pause", rep_left, 32'd1);
        chk("R10", "rep_active kept across pause", 32'(rep_active), 32'd1);
        op("R9", 3'd0, 3'd0, 32'h0, 32'h0, 3'b000, 16'h0, 2'd0, 0, 0, 16'h0403);
        chk("R9", "rep_left pass 2", rep_left, 32'd0);
        op("R9", 3'd0, 3'd0, 32'h0, 32'h0, 3'b000, 16'h0, 2'd0, 0, 0, 16'h0404);
        chk("R9", "rep_active after last", 32'(rep_active), 32'd0);
        op("R9", 3'd4, 3'd0, 32'd0, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0405);
        op("R9", 3'd0, 3'd0, 32'h0, 32'h0, 3'b000, 16'h0, 2'd0, 0, 0, 16'h0406);
        chk("R9", "single pass ends", 32'(rep_active), 32'd0);
    endtask

    task automatic t_wrap();
        op("R11", 3'd3, 3'd0, 32'h0, 32'h0, 3'b000, 16'hFFF0, 2'd0, 0, 1, 16'hFFF0);
        op("R11", 3'd1, 3'd0, 32'h20, 32'h0, 3'b000, 16'h0, 2'd1, 0, 0, 16'h0011);
    endtask

    initial begin
        t_reset();
        t_branches();
        t_calls();
        t_exits();
        t_stall();
        t_repeat();
        t_wrap();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule